// File: doc/BRIEF.md
# Programmable Watchdog With Reset Steering

This block is a watchdog timer set up through a single byte-wide control register. The register carries a steering bit, a multiplier field and a resolution code. The countdown advances on a tick input that the surrounding chip supplies at sixteen pulses per second. The timeout therefore equals the multiplier times four raised to the resolution code, counted in sixteenths of a second.

Software services the watchdog in one of two ways. It can rewrite the register, which also clears the timeout flag, or it can read the register, which reloads the countdown from the stored value. When the count runs out, the block raises a sticky flag for a neighbouring flags register. The steering bit then picks the action. One choice raises a one-cycle system reset request, clears the whole control register and pulses a clear strobe toward the century bit of a neighbouring day/century register. The other choice raises a single one-cycle interrupt pulse and halts the countdown until the next service.

Top module: `wdt_reset_steer`

## Requirements
- R1: After reset, `wd_flag`, `irq`, `reset_req` and `day_clr` are 0, and a read of the control register returns 0x00.
- R2: The control register layout is: bit 7 is the steering bit, bits 6:2 are the multiplier M, and bits 1:0 are the resolution code C. After a write, the M·4^C-th `tick` cycle that follows ends the countdown. The expiry pulse appears on the outputs right after that clock edge.
- R3: A write clears `wd_flag` at the next edge. It also restarts the countdown from the written value, including while a countdown is running.
- R4: Writing 0x00 stops the watchdog. No expiry follows, even if a countdown was running.
- R5: A nonzero value whose multiplier field is zero also disables the watchdog, so no expiry follows.
- R6: A read (`rd_en`) returns the stored register on `rd_data` one cycle later. It also reloads the countdown to the full timeout of the stored value.
- R7: Expiry sets `wd_flag`. The flag stays set across reads and further ticks until the next write or reset.
- R8: Expiry with bit 7 set raises `reset_req` and `day_clr` together for exactly one cycle and clears the control register to 0x00.
- R9: Expiry with bit 7 clear raises `irq` for exactly one cycle and keeps the register. No further expiry occurs until a write or read services the watchdog.
- R10: Ticks while the watchdog is disabled have no effect, and `irq` and `reset_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Value written to the control register |
| rd_en | input | 1 | Read strobe; services the watchdog |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| tick | input | 1 | One-cycle pulse every 1/16 second |
| wd_flag | output | 1 | Sticky timeout flag toward the flags register |
| reset_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |
| day_clr | output | 1 | One-cycle clear strobe for the century bit |

## Verification
The hardest case to reach is the exact expiry cycle for every multiplier and resolution pair, because the longest setting needs almost two thousand ticks. The bench holds `tick` high on every cycle after each write. It then sweeps all 124 enabled settings and counts cycles until the pulse, comparing each count with M·4^C computed in the bench. Service during a running countdown is reached by stopping the tick stream partway through, then issuing a read or a write and counting the full timeout again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // action taken when the countdown runs out
  typedef enum logic {
    STEER_IRQ   = 1'b0,
    STEER_RESET = 1'b1
  } steer_e;

  // width of a counter holding mult * 4^(2^res_w - 1)
  function automatic int unsigned cnt_width(int unsigned mult_w, int unsigned res_w);
    return mult_w + 2 * ((1 << res_w) - 1);
  endfunction

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode #(
  parameter int unsigned MULT_W = 5,
  parameter int unsigned RES_W  = 2,
  parameter int unsigned CNT_W  = wdt_pkg::cnt_width(MULT_W, RES_W)
) (
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic [CNT_W-1:0]  ticks
);
  localparam int unsigned NCODES = 1 << RES_W;

  logic [CNT_W-1:0] cand [NCODES];
  logic [CNT_W-1:0] mult_ext;

  assign mult_ext = {{(CNT_W-MULT_W){1'b0}}, mult};

  // one scaled candidate per resolution code: mult * 4^k
  for (genvar k = 0; k < NCODES; k++) begin : g_scale
    assign cand[k] = mult_ext << (2 * k);
  end

  assign ticks = cand[res];
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] count_q;
  logic             armed_q;

  // a service in the same cycle wins over the final tick
  assign expire = armed_q && tick && !load && (count_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      armed_q <= |load_val;
    end else if (armed_q && tick) begin
      count_q <= count_q - CNT_W'(1);
      if (count_q == CNT_W'(1))
        armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              expire,
  output logic [DATA_W-1:0] reg_q,
  output logic [DATA_W-1:0] rd_q,
  output logic              flag_q,
  output logic              rreq_q,
  output logic              irq_q,
  output logic              dclr_q
);
  import wdt_pkg::*;

  steer_e steer;
  assign steer = steer_e'(reg_q[DATA_W-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q  <= '0;
      rd_q   <= '0;
      flag_q <= 1'b0;
      rreq_q <= 1'b0;
      irq_q  <= 1'b0;
      dclr_q <= 1'b0;
    end else begin
      rreq_q <= 1'b0;
      irq_q  <= 1'b0;
      dclr_q <= 1'b0;
      if (rd_en)
        rd_q <= reg_q;
      if (wr_en) begin
        reg_q  <= wr_data;
        flag_q <= 1'b0;
      end else if (expire) begin
        flag_q <= 1'b1;
        if (steer == STEER_RESET) begin
          reg_q  <= '0;
          rreq_q <= 1'b1;
          dclr_q <= 1'b1;
        end else begin
          irq_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_reset_steer.sv
module wdt_reset_steer #(
  parameter int unsigned MULT_W = 5,
  parameter int unsigned RES_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [MULT_W+RES_W:0]     wr_data,
  input  logic                      rd_en,
  output logic [MULT_W+RES_W:0]     rd_data,
  input  logic                      tick,
  output logic                      wd_flag,
  output logic                      reset_req,
  output logic                      irq,
  output logic                      day_clr
);
  localparam int unsigned DATA_W = MULT_W + RES_W + 1;
  localparam int unsigned CNT_W  = wdt_pkg::cnt_width(MULT_W, RES_W);

  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] src;
  logic [CNT_W-1:0]  timeout;
  logic              load;
  logic              expire;

  // a write loads the new value, a read reloads the stored one
  assign load = wr_en | rd_en;
  assign src  = wr_en ? wr_data : reg_q;

  wdt_decode #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_dec (
    .mult  (src[DATA_W-2:RES_W]),
    .res   (src[RES_W-1:0]),
    .ticks (timeout)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (timeout),
    .tick     (tick),
    .expire   (expire)
  );

  wdt_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .expire  (expire),
    .reg_q   (reg_q),
    .rd_q    (rd_data),
    .flag_q  (wd_flag),
    .rreq_q  (reset_req),
    .irq_q   (irq),
    .dclr_q  (day_clr)
  );
endmodule

// File: rtl/wdt_reset_steer_chk.sv
module wdt_reset_steer_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic wd_flag,
  input logic reset_req,
  input logic irq,
  input logic day_clr
);
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(irq && reset_req));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> wd_flag);

  assert_reset_pair_R8: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (day_clr && wd_flag));

  assert_reset_single_R8: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  assert_write_clears_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wd_flag);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wd_flag && !wr_en) |=> wd_flag);
endmodule

bind wdt_reset_steer wdt_reset_steer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wd_flag   (wd_flag),
  .reset_req (reset_req),
  .irq       (irq),
  .day_clr   (day_clr)
);

// File: tb/sim_wdt_reset_steer.sv
module sim_wdt_reset_steer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic       wd_flag, reset_req, irq, day_clr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_reset_steer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tick(tick),
    .wd_flag(wd_flag), .reset_req(reset_req), .irq(irq), .day_clr(day_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); tick = 1'b0; wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); tick = 1'b0; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  // tick every cycle; count cycles until the chosen pulse (0 irq, 1 reset)
  task automatic run_until(input bit want_rst, input int limit, output int n, output bit both);
    n = 0; both = 1'b0;
    tick = 1'b1;
    while (n < limit) begin
      @(posedge clk); #1;
      n++;
      if (irq && reset_req) both = 1'b1;
      if (want_rst ? reset_req : irq) break;
    end
    if (n >= limit) n = -1;
    tick = 1'b0;
  endtask

  task automatic run_ticks(input int k, output int seen);
    seen = 0;
    tick = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      if (irq || reset_req) seen++;
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, seen, e;
    bit both;
    logic [7:0] rv;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!wd_flag && !irq && !reset_req && !day_clr, "R1 outputs", {wd_flag, irq, reset_req, day_clr}, 0);
    do_read(rv);
    chk(rv == 8'h00, "R1 read", rv, 0);

    // R10 idle ticks do nothing
    run_ticks(40, seen);
    chk(seen == 0 && !wd_flag, "R10 idle ticks", seen, 0);

    // R2 sweep over every enabled setting, interrupt steering
    for (int m = 1; m < 32; m++) begin
      for (int r = 0; r < 4; r++) begin
        e = m << (2 * r);
        do_write({1'b0, 5'(m), 2'(r)});
        run_until(1'b0, e + 8, n, both);
        chk(n == e && !both, "R2 timeout", n, e);
      end
    end

    // R5 zero multiplier with nonzero resolution disables
    for (int r = 1; r < 4; r++) begin
      do_write({1'b0, 5'd0, 2'(r)});
      run_ticks(80, seen);
      chk(seen == 0 && !wd_flag, "R5 disabled", seen, 0);
    end

    // R9 single irq, then halted, register kept
    do_write(8'h0C);                   // M=3 C=0
    run_until(1'b0, 20, n, both);
    chk(n == 3, "R9 expiry", n, 3);
    @(posedge clk); #1;
    chk(!irq, "R9 single pulse", irq, 0);
    chk(wd_flag, "R7 flag set", wd_flag, 1);
    run_ticks(30, seen);
    chk(seen == 0, "R9 halted", seen, 0);
    chk(wd_flag, "R7 flag held over ticks", wd_flag, 1);
    do_read(rv);
    chk(rv == 8'h0C, "R9 register kept", rv, 8'h0C);
    chk(wd_flag, "R7 flag held over read", wd_flag, 1);
    // read restarts it
    run_until(1'b0, 20, n, both);
    chk(n == 3, "R6 read restarts after halt", n, 3);

    // R3 write clears flag
    do_write(8'h14);                   // M=5 C=0
    chk(!wd_flag, "R3 flag cleared", wd_flag, 0);

    // R6 read reloads a running countdown
    run_ticks(3, seen);
    do_read(rv);
    chk(rv == 8'h14, "R6 read data", rv, 8'h14);
    run_until(1'b0, 20, n, both);
    chk(n == 5, "R6 reload", n, 5);

    // R3 write restarts a running countdown
    do_write(8'h18);                   // M=6
    run_ticks(4, seen);
    do_write(8'h18);
    run_until(1'b0, 20, n, both);
    chk(n == 6, "R3 restart", n, 6);

    // R4 zero stops a running countdown
    do_write(8'h0C);
    run_ticks(2, seen);
    do_write(8'h00);
    run_ticks(50, seen);
    chk(seen == 0 && !wd_flag, "R4 stop", seen, 0);

    // R8 reset steering
    do_write(8'h89);                   // steer=1 M=2 C=1 -> 8 ticks
    run_until(1'b1, 30, n, both);
    chk(n == 8, "R8 expiry", n, 8);
    chk(day_clr && !irq, "R8 day clear with reset", {day_clr, irq}, 2);
    @(posedge clk); #1;
    chk(!reset_req && !day_clr, "R8 single pulse", {reset_req, day_clr}, 0);
    chk(wd_flag, "R7 flag after reset steer", wd_flag, 1);
    do_read(rv);
    chk(rv == 8'h00, "R8 register cleared", rv, 0);
    run_ticks(60, seen);
    chk(seen == 0, "R8 no second expiry", seen, 0);

    // R1 reset clears flag
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!wd_flag, "R1 reset clears flag", wd_flag, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule